// File: doc/BRIEF.md
# Fixed-Latency Trigger Pipeline Buffer

This block holds the readout path for one group of detector channels. On every crossing clock it writes the full group sample into a circular latency pipeline. The pipeline is exactly as deep as the trigger decision time. When the trigger raises its accept for a crossing, the block takes the sample written that many crossings earlier. It tags the sample with the crossing count of the accept cycle and queues both in a small derandomizing FIFO.

A formatter drains the FIFO onto an output link that the serializer paces with a ready signal. Each event goes out as a header word carrying the crossing count, followed by one word for each channel whose value is above a programmable threshold. Channels at or below the threshold are dropped. As the FIFO fills, a hold-off flag with hysteresis asks the trigger source to pause. Accepts that arrive while the FIFO is full are discarded and counted. A synchronous reset command restarts the crossing count and the pipeline write position, and it empties the queue in the same cycle.

Top module: `trig_pipe_buffer`

## Requirements
- R1: An accept during crossing k yields the group sample that was presented during crossing k-160. The accept is honoured only from crossing 160 after reset onward.
- R2: Every event begins with a word flagged as header. Bits [11:0] of that word hold the crossing count of the accept cycle. The count is 0 on the first crossing after reset, advances by one per crossing and wraps from 4095 to 0.
- R3: After the header, one word follows per channel whose 10-bit value is strictly greater than the threshold, in ascending channel order. Bits [11:10] hold the channel index and bits [9:0] hold the value. An event with no such channel consists of the header alone.
- R4: Events leave the link in the order their accepts arrived, and every accepted event is emitted.
- R5: While the link holds valid with ready low, the word and the header flag stay unchanged until the word is taken.
- R6: Hold-off goes high on the cycle after the FIFO occupancy reaches 12 events. It stays high until occupancy falls to 8 or fewer.
- R7: The FIFO holds 16 events, and the event currently being sent occupies no FIFO slot. An accept that finds the FIFO full is discarded, and the overflow counter increases by one, saturating at 255.
- R8: A reset cycle clears the crossing count, the pipeline write position, the FIFO, the formatter and the overflow counter. Link valid and hold-off are low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock, one sample per cycle |
| rst | input | 1 | Synchronous reset command, active high |
| sample_in | input | 40 | Four 10-bit channel values, channel 0 in bits [9:0] |
| accept_in | input | 1 | Trigger accept for the sample 160 crossings back |
| zs_threshold | input | 10 | Suppression threshold; values must exceed it to be sent |
| link_ready | input | 1 | Link takes the current word at this edge |
| link_valid | output | 1 | A word is presented on the link |
| link_is_header | output | 1 | Presented word is an event header |
| link_word | output | 12 | Header count or channel index and value |
| hold_off | output | 1 | Request to pause accepts; asserted near full |
| ovf_count | output | 8 | Saturating count of accepts dropped on a full FIFO |

## Verification
The embedded assertions assume the trigger source issues accepts only after the pipeline has been written once since reset. They also assume the threshold changes only while no accepted event is waiting or being formatted, because the threshold is sampled when an event leaves the FIFO. The stimulus respects both conditions. It starts every accept at least 160 crossings after a reset, and it changes the threshold only after the scoreboard has drained. Within those limits, the bench stresses the link with random ready patterns and drives a burst with ready held low, so the FIFO reaches full and discards accepts.

// File: rtl/tpb_pkg.sv
package tpb_pkg;

   typedef enum logic [1:0] {
      FMT_IDLE = 2'd0,
      FMT_HDR  = 2'd1,
      FMT_DATA = 2'd2
   } fmt_state_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/tpb_latency_pipe.sv
module tpb_latency_pipe #(
   parameter int SAMPLE_W = 40,
   parameter int LATENCY  = 160
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [SAMPLE_W-1:0] wr_data,
   output logic [SAMPLE_W-1:0] aged_data
);
   localparam int AW = (LATENCY > 1) ? $clog2(LATENCY) : 1;
   localparam bit POW2 = ((1 << AW) == LATENCY);

   if (LATENCY < 2) begin : g_bad_latency
      $error("tpb_latency_pipe: LATENCY must be at least 2");
   end
   if (SAMPLE_W < 1) begin : g_bad_width
      $error("tpb_latency_pipe: SAMPLE_W must be positive");
   end

   logic [SAMPLE_W-1:0] store [LATENCY];
   logic [AW-1:0]       wp;

   // The slot about to be overwritten holds the sample from LATENCY crossings ago.
   assign aged_data = store[wp];

   always_ff @(posedge clk) begin
      store[wp] <= wr_data;
   end

   if (POW2) begin : g_ptr_wrap
      always_ff @(posedge clk) begin
         if (rst) wp <= '0;
         else     wp <= wp + 1'b1;
      end
   end else begin : g_ptr_cmp
      always_ff @(posedge clk) begin
         if (rst)                                wp <= '0;
         else if (wp == AW'(LATENCY - 1))        wp <= '0;
         else                                    wp <= wp + 1'b1;
      end
   end

   // R1
   ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
      int'(wp) < LATENCY);

   // R8
   ptr_restart_chk: assert property (@(posedge clk)
      rst |=> wp == '0);

endmodule

// File: rtl/tpb_derand_fifo.sv
module tpb_derand_fifo #(
   parameter int ENTRY_W  = 52,
   parameter int DEPTH    = 16,
   parameter int HOLD_ON  = 12,
   parameter int HOLD_OFF = 8,
   parameter int OVF_W    = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               push,
   input  logic [ENTRY_W-1:0] push_data,
   input  logic               pop,
   output logic [ENTRY_W-1:0] head_data,
   output logic               not_empty,
   output logic               hold_off,
   output logic [OVF_W-1:0]   ovf_count
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = AW + 1;

   if ((1 << AW) != DEPTH || DEPTH < 2) begin : g_bad_depth
      $error("tpb_derand_fifo: DEPTH must be a power of two, at least 2");
   end
   if (!(HOLD_OFF < HOLD_ON && HOLD_ON <= DEPTH)) begin : g_bad_marks
      $error("tpb_derand_fifo: need HOLD_OFF < HOLD_ON <= DEPTH");
   end

   logic [ENTRY_W-1:0] slots [DEPTH];
   logic [AW-1:0]      wr_ptr, rd_ptr;
   logic [CW-1:0]      occ, occ_nxt;
   logic               full, do_wr, do_rd;

   assign full      = (occ == CW'(DEPTH));
   assign not_empty = (occ != '0);
   assign do_wr     = push && !full;
   assign do_rd     = pop && not_empty;
   assign head_data = slots[rd_ptr];

   always_comb begin
      occ_nxt = occ;
      if (do_wr && !do_rd) occ_nxt = occ + 1'b1;
      if (do_rd && !do_wr) occ_nxt = occ - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_wr) slots[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr    <= '0;
         rd_ptr    <= '0;
         occ       <= '0;
         hold_off  <= 1'b0;
         ovf_count <= '0;
      end else begin
         if (do_wr) wr_ptr <= wr_ptr + 1'b1;
         if (do_rd) rd_ptr <= rd_ptr + 1'b1;
         occ <= occ_nxt;
         if (occ_nxt >= CW'(HOLD_ON))       hold_off <= 1'b1;
         else if (occ_nxt <= CW'(HOLD_OFF)) hold_off <= 1'b0;
         if (push && full && ovf_count != '1) ovf_count <= ovf_count + 1'b1;
      end
   end

   // R7
   occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
      int'(occ) <= DEPTH);

   // R7
   drop_count_chk: assert property (@(posedge clk) disable iff (rst)
      (push && full && ovf_count != '1) |=> ovf_count == $past(ovf_count) + 1'b1);

   // R7
   drop_keeps_occ_chk: assert property (@(posedge clk) disable iff (rst)
      (push && full && !pop) |=> occ == CW'(DEPTH));

   // R6
   hold_raise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(hold_off) |-> occ >= CW'(HOLD_ON));

   // R6
   hold_release_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(hold_off) |-> occ <= CW'(HOLD_OFF));

endmodule

// File: rtl/tpb_zs_formatter.sv
module tpb_zs_formatter
   import tpb_pkg::*;
#(
   parameter int NCH    = 4,
   parameter int DATA_W = 10,
   parameter int BC_W   = 12,
   parameter int OUT_W  = 12,
   parameter bit ZS_EN  = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  ev_avail,
   input  logic [NCH*DATA_W-1:0] ev_samples,
   input  logic [BC_W-1:0]       ev_bcnt,
   input  logic [DATA_W-1:0]     threshold,
   input  logic                  link_ready,
   output logic                  ev_pop,
   output logic                  link_valid,
   output logic                  link_is_header,
   output logic [OUT_W-1:0]      link_word
);
   localparam int CHI_W = (NCH > 1) ? $clog2(NCH) : 1;

   if (OUT_W < BC_W || OUT_W < CHI_W + DATA_W) begin : g_bad_out
      $error("tpb_zs_formatter: OUT_W too narrow for header or data word");
   end

   fmt_state_e            state;
   logic [NCH*DATA_W-1:0] smp_q;
   logic [BC_W-1:0]       bc_q;
   logic [NCH-1:0]        mask_q, mask_nxt, keep;
   logic [CHI_W-1:0]      pick;

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      if (ZS_EN) begin : g_zs
         assign keep[g] = ev_samples[g*DATA_W +: DATA_W] > threshold;
      end else begin : g_all
         assign keep[g] = 1'b1;
      end
   end

   // Lowest pending channel goes first.
   always_comb begin
      pick = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (mask_q[i]) pick = CHI_W'(i);
      end
      mask_nxt = mask_q & ~(NCH'(1) << pick);
   end

   assign ev_pop         = (state == FMT_IDLE) && ev_avail;
   assign link_valid     = (state != FMT_IDLE);
   assign link_is_header = (state == FMT_HDR);

   always_comb begin
      link_word = '0;
      if (state == FMT_HDR) begin
         link_word[BC_W-1:0] = bc_q;
      end else if (state == FMT_DATA) begin
         link_word[DATA_W-1:0]       = smp_q[pick*DATA_W +: DATA_W];
         link_word[DATA_W +: CHI_W]  = pick;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= FMT_IDLE;
         smp_q  <= '0;
         bc_q   <= '0;
         mask_q <= '0;
      end else begin
         unique case (state)
            FMT_IDLE: if (ev_avail) begin
               smp_q  <= ev_samples;
               bc_q   <= ev_bcnt;
               mask_q <= keep;
               state  <= FMT_HDR;
            end
            FMT_HDR: if (link_ready) begin
               state <= (mask_q != '0) ? FMT_DATA : FMT_IDLE;
            end
            FMT_DATA: if (link_ready) begin
               mask_q <= mask_nxt;
               if (mask_nxt == '0) state <= FMT_IDLE;
            end
            default: state <= FMT_IDLE;
         endcase
      end
   end

   // R5
   link_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (link_valid && !link_ready) |=> link_valid && $stable(link_word) && $stable(link_is_header));

   // R2
   hdr_first_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(link_valid) |-> link_is_header);

   // R3
   data_pending_chk: assert property (@(posedge clk) disable iff (rst)
      (link_valid && !link_is_header) |-> $countones(mask_q) >= 1);

endmodule

// File: rtl/trig_pipe_buffer.sv
module trig_pipe_buffer
   import tpb_pkg::*;
#(
   parameter int NCH        = 4,
   parameter int DATA_W     = 10,
   parameter int LATENCY    = 160,
   parameter int BC_W       = 12,
   parameter int FIFO_DEPTH = 16,
   parameter int HOLD_ON    = 12,
   parameter int HOLD_OFF   = 8,
   parameter int OVF_W      = 8,
   parameter bit ZS_EN      = 1'b1,
   localparam int SAMPLE_W  = NCH * DATA_W,
   localparam int CHI_W     = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int OUT_W     = max_int(BC_W, CHI_W + DATA_W)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [SAMPLE_W-1:0] sample_in,
   input  logic                accept_in,
   input  logic [DATA_W-1:0]   zs_threshold,
   input  logic                link_ready,
   output logic                link_valid,
   output logic                link_is_header,
   output logic [OUT_W-1:0]    link_word,
   output logic                hold_off,
   output logic [OVF_W-1:0]    ovf_count
);
   localparam int ENTRY_W = SAMPLE_W + BC_W;

   if (NCH < 1 || DATA_W < 1 || BC_W < 1 || OVF_W < 1) begin : g_bad_top
      $error("trig_pipe_buffer: widths and channel count must be positive");
   end

   logic [BC_W-1:0]     bcnt;
   logic [SAMPLE_W-1:0] aged;
   logic [ENTRY_W-1:0]  head;
   logic                q_avail, q_pop;

   always_ff @(posedge clk) begin
      if (rst) bcnt <= '0;
      else     bcnt <= bcnt + 1'b1;
   end

   tpb_latency_pipe #(
      .SAMPLE_W (SAMPLE_W),
      .LATENCY  (LATENCY)
   ) u_pipe (
      .clk       (clk),
      .rst       (rst),
      .wr_data   (sample_in),
      .aged_data (aged)
   );

   tpb_derand_fifo #(
      .ENTRY_W  (ENTRY_W),
      .DEPTH    (FIFO_DEPTH),
      .HOLD_ON  (HOLD_ON),
      .HOLD_OFF (HOLD_OFF),
      .OVF_W    (OVF_W)
   ) u_derand (
      .clk       (clk),
      .rst       (rst),
      .push      (accept_in),
      .push_data ({bcnt, aged}),
      .pop       (q_pop),
      .head_data (head),
      .not_empty (q_avail),
      .hold_off  (hold_off),
      .ovf_count (ovf_count)
   );

   tpb_zs_formatter #(
      .NCH    (NCH),
      .DATA_W (DATA_W),
      .BC_W   (BC_W),
      .OUT_W  (OUT_W),
      .ZS_EN  (ZS_EN)
   ) u_fmt (
      .clk            (clk),
      .rst            (rst),
      .ev_avail       (q_avail),
      .ev_samples     (head[SAMPLE_W-1:0]),
      .ev_bcnt        (head[ENTRY_W-1:SAMPLE_W]),
      .threshold      (zs_threshold),
      .link_ready     (link_ready),
      .ev_pop         (q_pop),
      .link_valid     (link_valid),
      .link_is_header (link_is_header),
      .link_word      (link_word)
   );

   // R8
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!link_valid && !hold_off && ovf_count == '0 && bcnt == '0));

   // R2
   bcnt_advance_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> bcnt == $past(bcnt) + 1'b1);

endmodule

// File: tb/tb_trig_pipe_buffer.sv
module tb_trig_pipe_buffer;
   localparam int LAT = 160;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [39:0] sample_in = '0;
   logic        accept_in = 1'b0;
   logic [9:0]  zs_threshold = 10'd500;
   logic        link_ready = 1'b1;
   logic        link_valid, link_is_header, hold_off;
   logic [11:0] link_word;
   logic [7:0]  ovf_count;

   trig_pipe_buffer dut (
      .clk(clk), .rst(rst), .sample_in(sample_in), .accept_in(accept_in),
      .zs_threshold(zs_threshold), .link_ready(link_ready),
      .link_valid(link_valid), .link_is_header(link_is_header),
      .link_word(link_word), .hold_off(hold_off), .ovf_count(ovf_count)
   );

   always #4 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   int nxt    = 0;
   logic [39:0] hist [256];
   logic [12:0] exp_q [$];
   bit          done = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // Scoreboard driver side: derive the words an accept must produce.
   task automatic expect_event(input int idx);
      logic [39:0] src;
      logic [9:0]  v;
      src = hist[(idx - LAT) % 256];
      exp_q.push_back({1'b1, 12'(idx % 4096)});
      for (int ch = 0; ch < 4; ch++) begin
         v = src[ch*10 +: 10];
         if (v > zs_threshold) exp_q.push_back({1'b0, 2'(ch), v});
      end
   endtask

   task automatic tick(input logic [39:0] smp, input bit acc, input bit keep);
      @(negedge clk);
      sample_in = smp;
      accept_in = acc;
      if (!rst) begin
         hist[nxt % 256] = smp;
         if (acc && keep) expect_event(nxt);
      end
      @(posedge clk);
      #1;
      if (rst) nxt = 0;
      else     nxt++;
   endtask

   function automatic logic [39:0] rnd40();
      return {$urandom(), $urandom()} & 40'hFF_FFFF_FFFF;
   endfunction

   task automatic drain();
      link_ready = 1'b1;
      for (int i = 0; i < 3000; i++) begin
         if (exp_q.size() == 0 && !link_valid) break;
         tick(rnd40(), 1'b0, 1'b1);
      end
      // R4
      chk(exp_q.size() == 0, "R4 all accepted events emitted", exp_q.size(), 0);
   endtask

   // Scoreboard monitor side.
   initial begin
      bit          held_v;
      logic [12:0] held;
      logic [12:0] e;
      held_v = 1'b0;
      forever begin
         @(negedge clk);
         #3;
         if (rst) begin
            held_v = 1'b0;
         end else begin
            if (held_v) begin
               // R5
               chk(link_valid && {link_is_header, link_word} == held,
                   "R5 word held while not ready", int'({link_is_header, link_word}), int'(held));
               held_v = 1'b0;
            end
            if (link_valid && link_ready) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R4 unexpected link word", int'({link_is_header, link_word}), -1);
               end else begin
                  e = exp_q.pop_front();
                  // R1 R2 R3 R4
                  chk({link_is_header, link_word} == e, "R1 R2 R3 R4 link word",
                      int'({link_is_header, link_word}), int'(e));
               end
            end else if (link_valid) begin
               held   = {link_is_header, link_word};
               held_v = 1'b1;
            end
         end
      end
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [39:0] s;
      int          base;
      rst = 1'b1;
      repeat (3) tick(40'd0, 1'b0, 1'b1);
      rst = 1'b0;
      // R8 reset state
      chk(!link_valid, "R8 link idle after reset", int'(link_valid), 0);
      chk(!hold_off, "R8 hold-off low after reset", int'(hold_off), 0);
      chk(ovf_count == 0, "R8 overflow counter clear", int'(ovf_count), 0);

      // R1 R3: crafted samples every 40 crossings, accepted LAT later.
      zs_threshold = 10'd500;
      base = nxt;
      for (int i = 0; i < 360; i++) begin
         if (i % 40 == 0) begin
            case ((i / 40) % 4)
               0: s = {10'd500, 10'd501, 10'd10, 10'd600};
               1: s = 40'd0;
               2: s = {4{10'd1023}};
               default: s = {10'd501, 10'd500, 10'd500, 10'd500};
            endcase
         end else begin
            s = rnd40();
         end
         tick(s, (i >= LAT) && ((i - LAT) % 40 == 0), 1'b1);
      end
      drain();

      // R4 R5: back-to-back accepts under a random ready pattern.
      zs_threshold = 10'd200;
      for (int i = 0; i < 10; i++) begin
         link_ready = 1'($urandom());
         tick(rnd40(), 1'b1, 1'b1);
      end
      for (int i = 0; i < 80; i++) begin
         link_ready = 1'($urandom());
         tick(rnd40(), 1'b0, 1'b1);
      end
      drain();

      // R6 R7: burst with the link stalled.
      zs_threshold = 10'd500;
      link_ready = 1'b0;
      for (int j = 0; j < 20; j++) begin
         tick(rnd40(), 1'b1, j < 17);
         if (j == 11) chk(!hold_off, "R6 hold-off low at 11 queued", int'(hold_off), 0);
         if (j == 12) chk(hold_off, "R6 hold-off high at 12 queued", int'(hold_off), 1);
      end
      tick(rnd40(), 1'b0, 1'b1);
      chk(ovf_count == 8'd3, "R7 three accepts dropped when full", int'(ovf_count), 3);
      chk(hold_off, "R6 hold-off still high when full", int'(hold_off), 1);
      drain();
      chk(!hold_off, "R6 hold-off released after drain", int'(hold_off), 0);
      chk(ovf_count == 8'd3, "R7 counter steady without drops", int'(ovf_count), 3);

      // R2: crossing count wrap.
      while (nxt < 4300) tick(rnd40(), 1'b0, 1'b1);
      tick(rnd40(), 1'b1, 1'b1);
      drain();

      // R8: reset with events pending.
      link_ready = 1'b0;
      for (int j = 0; j < 3; j++) tick(rnd40(), 1'b1, 1'b1);
      rst = 1'b1;
      tick(rnd40(), 1'b0, 1'b1);
      rst = 1'b0;
      exp_q.delete();
      chk(!link_valid, "R8 queue flushed by reset", int'(link_valid), 0);
      chk(ovf_count == 0, "R8 overflow cleared by reset", int'(ovf_count), 0);
      chk(!hold_off, "R8 hold-off cleared by reset", int'(hold_off), 0);
      link_ready = 1'b1;
      for (int i = 0; i < 170; i++) tick(rnd40(), i == 163, 1'b1);
      drain();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule